// File: doc/BRIEF.md
# Blade-Tagged Multiply-Accumulate Hazard Controller

This block drives a multiply-accumulate path whose results are summed into register-file entries selected by an 8-bit blade tag. Each accepted input carries two signed 32-bit coefficients, a blade tag and a valid bit. The coefficients are multiplied in a five-stage pipeline. The product then enters a six-stage adder, where it is added to the current register-file value for its tag. The sum leaves the last adder stage as a register-file write. Tag and valid bits travel with the data through every stage.

Because the adder is pipelined, a product can reach the adder while an earlier sum for the same tag is still in flight. Such a product would then read a stale register value. To prevent this, the block compares the tag leaving the multiplier with the tag of every valid adder stage. On any match it freezes the multiplier and the input, and feeds invalid, tag-zero bubbles into the adder. The adder keeps draining, and the stall releases once the conflicting sum has been written.

The register file itself is outside the block. It offers an asynchronous read port addressed by `rd_tag`, and a write port that is sampled on the clock edge. A tag that has never been written reads as zero.

Top module: `blade_stall_ctrl`

## Requirements
- R1: While reset is held low and in the first cycle after it, `in_ready` is 1, `wr_en` is 0 and `idle` is 1.
- R2: An input accepted on a clock edge, with no stall following it, shows `wr_en` high with `wr_tag` equal to its tag after the eleventh clock edge, counting the accepting edge as the first.
- R3: The written data is the low 32 bits of the signed product of the two coefficients, plus `rd_data`. `rd_data` is read with `rd_tag` equal to the product's tag in the cycle the product enters the adder.
- R4: A valid product leaving the multiplier whose tag equals that of a valid adder stage k (k = 1..6) stalls for 7 − k cycles. Back-to-back equal tags stall 6 cycles, a gap of four other tags stalls 2 cycles, and a gap of five stalls 1 cycle.
- R5: No stall occurs when the conflicting earlier product is six or more inputs ahead. No stall occurs for distinct tags. Invalid adder stages, including the tag-0 contents after reset, never cause a stall.
- R6: While `in_ready` is 0, the input is not accepted and `rd_tag` holds its value.
- R7: Every accepted input produces exactly one write, writes come out in acceptance order, and each tag's written value is the running sum of its products under any interleaving.
- R8: `idle` is 1 exactly when `in_valid` is 0 and no valid data remains in any pipeline stage.
- R9: A single stall never lasts more than 6 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input coefficient pair is valid |
| in_a | input | 32 | First signed coefficient |
| in_b | input | 32 | Second signed coefficient |
| in_tag | input | 8 | Blade tag of the input |
| in_ready | output | 1 | Input accepted on this edge when high (low during a stall) |
| rd_tag | output | 8 | Register-file read tag (product entering the adder) |
| rd_data | input | 32 | Register-file read data for rd_tag |
| wr_en | output | 1 | Register-file write strobe |
| wr_tag | output | 8 | Register-file write tag |
| wr_data | output | 32 | Register-file write data |
| idle | output | 1 | No input pending and all stages empty |

## Verification
A wrong tag comparison or a missing valid qualifier shows in one of two ways at the ports. It may appear as a lost accumulation, where a written sum omits an earlier product about eleven to seventeen cycles after the second input. Or it may appear as stall cycles counted on `in_ready` that differ from the 7 − k rule within a few cycles. A bubble wrongly marked valid produces an extra write, which is seen as an unmatched write. A frozen stage that fails to hold its contents changes `rd_tag` during a stall in the very next cycle.

// File: rtl/blade_stall_ctrl.sv
module blade_stall_ctrl #(
  parameter int DW     = 32,
  parameter int TW     = 8,
  parameter int MUL_ST = 5,
  parameter int ADD_ST = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [TW-1:0] in_tag,
  output logic          in_ready,
  output logic [TW-1:0] rd_tag,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [TW-1:0] wr_tag,
  output logic [DW-1:0] wr_data,
  output logic          idle
);
  localparam int ML = MUL_ST - 1;
  localparam int AL = ADD_ST - 1;

  logic [MUL_ST-1:0] mv;
  logic [TW-1:0]     mt [MUL_ST];
  logic [DW-1:0]     mp [MUL_ST];
  logic [ADD_ST-1:0] av;
  logic [TW-1:0]     at [ADD_ST];
  logic [DW-1:0]     as [ADD_ST];
  logic [ADD_ST-1:0] hit;
  logic              stall;
  logic signed [2*DW-1:0] full;

  assign full = $signed(in_a) * $signed(in_b);

  always_comb
    for (int k = 0; k < ADD_ST; k++)
      hit[k] = mv[ML] && av[k] && (at[k] == mt[ML]);

  assign stall    = |hit;
  assign in_ready = !stall;
  assign rd_tag   = mt[ML];
  assign wr_en    = av[AL];
  assign wr_tag   = at[AL];
  assign wr_data  = as[AL];
  assign idle     = !in_valid && !(|mv) && !(|av);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mv <= '0;
      av <= '0;
      for (int k = 0; k < MUL_ST; k++) begin
        mt[k] <= '0;
        mp[k] <= '0;
      end
      for (int k = 0; k < ADD_ST; k++) begin
        at[k] <= '0;
        as[k] <= '0;
      end
    end else begin
      if (!stall) begin
        mv    <= {mv[MUL_ST-2:0], in_valid};
        mt[0] <= in_tag;
        mp[0] <= full[DW-1:0];
        for (int k = 1; k < MUL_ST; k++) begin
          mt[k] <= mt[k-1];
          mp[k] <= mp[k-1];
        end
      end
      av    <= {av[ADD_ST-2:0], mv[ML] && !stall};
      at[0] <= stall ? '0 : mt[ML];
      as[0] <= stall ? '0 : mp[ML] + rd_data;
      for (int k = 1; k < ADD_ST; k++) begin
        at[k] <= at[k-1];
        as[k] <= as[k-1];
      end
    end
  end
endmodule

// File: rtl/blade_stall_ctrl_chk.sv
module blade_stall_ctrl_chk #(
  parameter int TW     = 8,
  parameter int ADD_ST = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic [TW-1:0] rd_tag,
  input logic          wr_en,
  input logic          idle
);
  logic [3:0] run;
  logic       seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= '0;
      seen <= 1'b0;
    end else begin
      seen <= 1'b1;
      run  <= in_ready ? '0 : run + 4'd1;
    end
  end

  // R1
  first_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (!wr_en && in_ready));

  // R6
  stall_holds_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !in_ready) |=> $stable(rd_tag));

  // R8
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !wr_en);

  // R9
  stall_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (run < 4'(ADD_ST)));
endmodule

bind blade_stall_ctrl blade_stall_ctrl_chk #(.TW(TW), .ADD_ST(ADD_ST)) u_chk (.*);

// File: tb/blade_stall_ctrl_tb.sv
module blade_stall_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [31:0] in_a = 0, in_b = 0;
  logic [7:0]  in_tag = 0;
  logic        in_ready, wr_en, idle;
  logic [7:0]  rd_tag, wr_tag;
  logic [31:0] rd_data, wr_data;

  logic [31:0] rf [256];
  logic [31:0] acc [256];
  logic [39:0] q [$];
  int checks = 0, errors = 0, stalls = 0;

  always #4 clk = ~clk;

  blade_stall_ctrl u_dut (.*);

  assign rd_data = rf[rd_tag];

  always @(posedge clk) if (wr_en) rf[wr_tag] <= wr_data;

  function automatic logic [31:0] mulx(logic [31:0] a, logic [31:0] b);
    logic signed [63:0] f;
    f = $signed(a) * $signed(b);
    return f[31:0];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !in_ready) stalls++;
    if (rst_n && wr_en) begin
      if (q.size() == 0) chk(0, "R7 unmatched write", {wr_tag, wr_data}, 0);
      else begin
        logic [39:0] e;
        e = q.pop_front();
        chk({wr_tag, wr_data} == e, "R3 R7 write tag/data", {wr_tag, wr_data}, e);
      end
    end
  end

  task automatic send(logic [7:0] t, logic [31:0] a, logic [31:0] b);
    in_valid = 1; in_tag = t; in_a = a; in_b = b;
    while (!in_ready) @(negedge clk);
    acc[t] = acc[t] + mulx(a, b);
    q.push_back({t, acc[t]});
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    in_valid = 0;
    while (!idle) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stall_case(int gap, int exp, string req);
    drain();
    stalls = 0;
    send(8'd9, 32'd3, 32'hFFFF_FFFE);
    for (int i = 0; i < gap; i++) send(8'(20 + i), 32'd1, 32'd1);
    send(8'd9, 32'd5, 32'd7);
    drain();
    chk(stalls == exp, req, stalls, exp);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin rf[i] = 0; acc[i] = 0; end
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(in_ready && !wr_en && idle, "R1 in reset", {in_ready, wr_en, idle}, 3'b101);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready && !wr_en && idle, "R1 after reset", {in_ready, wr_en, idle}, 3'b101);

    // R5: tag 0 against reset-state invalid stages
    stalls = 0;
    send(8'd0, 32'd6, 32'd7);
    chk(!idle, "R8 busy", idle, 0);
    drain();
    chk(stalls == 0, "R5 tag zero no stall", stalls, 0);
    chk(rf[0] == 42, "R3 first product", rf[0], 42);

    // R2 latency
    begin
      int cnt;
      send(8'd5, 32'hFFFF_FFFD, 32'd4);
      cnt = 1;
      while (!wr_en && cnt < 40) begin @(negedge clk); cnt++; end
      chk(cnt == 11 && wr_tag == 8'd5, "R2 latency", cnt, 11);
      chk(wr_data == 32'hFFFF_FFF4, "R3 signed product", wr_data, 32'hFFFF_FFF4);
    end

    stall_case(0, 6, "R4 back-to-back stall");
    stall_case(4, 2, "R4 stage5 stall");
    stall_case(5, 1, "R4 stage6 stall");
    stall_case(6, 0, "R5 gap six no stall");

    drain();
    stalls = 0;
    for (int i = 0; i < 12; i++) send(8'(40 + i), 32'(i), 32'd3);
    drain();
    chk(stalls == 0, "R5 distinct tags", stalls, 0);
    chk(idle, "R8 idle after drain", idle, 1);

    for (int i = 0; i < 400; i++) begin
      send(8'($urandom % 5 + 100), $urandom, $urandom);
      repeat ($urandom % 3) @(negedge clk);
    end
    drain();
    for (int t = 100; t < 105; t++)
      chk(rf[t] == acc[t], "R7 accumulated sum", rf[t], acc[t]);
    chk(q.size() == 0, "R7 all writes seen", q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule